// File: doc/BRIEF.md
# Sticky Event Status Register

This block keeps an 8-bit record of error and event conditions for an instrument's remote-control interface. Single-cycle strobes from the command parser, the command executor and the output-queue controller each set one fixed bit. A bit that has been set stays set until the register is cleared. The register clears when a clear-status strobe or an error-query strobe arrives. A synchronous active-low power-on reset also clears it, but leaves the power-on flag set.

An 8-bit enable mask, loaded through a write strobe, chooses which recorded bits count toward a summary flag. The summary is the OR of the register ANDed with the mask. It is presented on its own and also at bit 5 of a status-byte fragment, which downstream status-byte and service-request logic combines with its own bits. A query-error strobe also produces a one-cycle pulse that tells the output queue to flush.

Top module: `event_status_reg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the register becomes 0x80 (power-on flag at bit 7 set, all other bits 0), the mask becomes 0x00, and `oq_flush` becomes 0.
- R2: Any asserted bit of `parse_err` (four parser error kinds) sets bit 5, the command-error bit, at the next clock edge.
- R3: Any asserted bit of `exec_err` (out of range, setting refused, blocked by another operation) sets bit 4 at the next clock edge.
- R4: `dev_fault` sets bit 3, the device-dependent error bit, at the next clock edge.
- R5: Any asserted bit of `qry_err` (empty-queue read, overflow, data lost) sets bit 2 at the next clock edge. In that same cycle `oq_flush` is high, for exactly one cycle per strobe cycle.
- R6: `opc_done` sets bit 0, the operation-complete bit, at the next clock edge.
- R7: `pwr_resume` sets bit 7 at the next clock edge.
- R8: Bits 6 and 1 always read 0. The `user_req` and `ctl_req` strobes have no effect on the register or on the summary.
- R9: A set bit stays at 1 on every later edge until a clear strobe or reset arrives.
- R10: `clr_status` or `err_query` zeroes the register at the next edge. Set strobes present in the same cycle are then applied, so those bits read 1 afterwards.
- R11: When `mask_we` is high, `mask_q` takes the value of `mask_wdata` at the next edge. Otherwise `mask_q` holds.
- R12: `esb` is combinationally 1 exactly when some bit is 1 in both `status_q` and `mask_q`. `stb_frag` carries `esb` at bit 5 and 0 in every other bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| pwr_resume | input | 1 | Recovery-from-outage strobe |
| parse_err | input | 4 | Parser error strobes |
| exec_err | input | 3 | Execution error strobes |
| dev_fault | input | 1 | Internal fault strobe |
| qry_err | input | 3 | Output-queue error strobes |
| opc_done | input | 1 | Operation-complete strobe |
| user_req | input | 1 | Strobe for an unused bit (ignored) |
| ctl_req | input | 1 | Strobe for an unused bit (ignored) |
| clr_status | input | 1 | Clear-status command strobe |
| err_query | input | 1 | Error-query command strobe |
| mask_we | input | 1 | Enable-mask load strobe |
| mask_wdata | input | 8 | Enable-mask load value |
| status_q | output | 8 | Current register value |
| mask_q | output | 8 | Current enable mask |
| esb | output | 1 | Masked summary flag |
| stb_frag | output | 8 | Status-byte fragment, summary at bit 5 |
| oq_flush | output | 1 | Output-queue flush pulse |

## Verification
The bench targets several cycles where a design could go wrong. One is a clear arriving together with a set: a design that gives the clear priority would lose the event, leaving that bit at 0. Another is the first cycle after reset: a design that applied reset to bit 7 like every other bit would read 0x00 there instead of 0x80. The bench also drives the unused-bit strobes with the mask fully open, which would expose a design that stored them, because bit 6 or bit 1 and the summary would rise. Random traffic with rare clears checks that bits hold, that the flush pulse lasts only as long as the query strobes, and that the summary follows each mask write on the next cycle.

// File: rtl/esr_pkg.sv
// Shared constants for the sticky event status register.
// Assumes an 8-bit register and a fixed bit assignment per event class.
package esr_pkg;
    localparam int ESR_W      = 8;
    localparam int POS_PON    = 7;
    localparam int POS_USER   = 6;
    localparam int POS_CMD    = 5;
    localparam int POS_EXE    = 4;
    localparam int POS_DEV    = 3;
    localparam int POS_QRY    = 2;
    localparam int POS_CTL    = 1;
    localparam int POS_OPC    = 0;
    localparam int SB_SUM_POS = 5;
    // Bits that hold state; unused positions are forced to zero.
    localparam logic [ESR_W-1:0] ESR_IMPL = 8'b1011_1101;
    // Value after power-on: power flag set.
    localparam logic [ESR_W-1:0] ESR_RST  = 8'b1000_0000;
endpackage

// File: rtl/esr_event_map.sv
// Event map: folds the per-class strobe groups into one set vector
// with a fixed bit per class, and drops strobes aimed at unused bits.
// It also registers the output-queue flush pulse.
// Assumes every strobe is a single-cycle, synchronous pulse.
module esr_event_map
    import esr_pkg::*;
#(
    parameter int PAR_N = 4,
    parameter int EXE_N = 3,
    parameter int QRY_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_resume,
    input  logic [PAR_N-1:0] parse_err,
    input  logic [EXE_N-1:0] exec_err,
    input  logic             dev_fault,
    input  logic [QRY_N-1:0] qry_err,
    input  logic             opc_done,
    input  logic             user_req,
    input  logic             ctl_req,
    output logic [ESR_W-1:0] set_vec,
    output logic             oq_flush
);
    logic [ESR_W-1:0] raw_vec;

    // Place each event class at its fixed bit position.
    always_comb begin
        raw_vec           = '0;
        raw_vec[POS_PON]  = pwr_resume;
        raw_vec[POS_USER] = user_req;
        raw_vec[POS_CMD]  = |parse_err;
        raw_vec[POS_EXE]  = |exec_err;
        raw_vec[POS_DEV]  = dev_fault;
        raw_vec[POS_QRY]  = |qry_err;
        raw_vec[POS_CTL]  = ctl_req;
        raw_vec[POS_OPC]  = opc_done;
    end

    // Keep only the positions that hold state.
    assign set_vec = raw_vec & ESR_IMPL;

    // Flush pulse appears in the same cycle the query-error bit shows up.
    always_ff @(posedge clk) begin
        if (!rst_n) oq_flush <= 1'b0;
        else        oq_flush <= |qry_err;
    end

    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|qry_err) |=> oq_flush);                                   // R5
    AST_FLUSH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(|qry_err) |=> !oq_flush);                                 // R5
    AST_CMD_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|parse_err) |-> set_vec[POS_CMD]);                         // R2
    AST_UNUSED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec[POS_USER] == 1'b0) && (set_vec[POS_CTL] == 1'b0)); // R8
endmodule

// File: rtl/esr_sticky_bits.sv
// Sticky bit array: each implemented bit is set by its strobe and
// stays set until a clear.  A clear and a set in the same cycle
// resolve as clear first, then set.  Unimplemented bits stay at zero.
// Assumes a synchronous active-low reset that loads RST_VAL.
module esr_sticky_bits #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    IMPL    = '1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] set_vec,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic KEEP = IMPL[i];
        localparam logic INIT = RST_VAL[i] & IMPL[i];
        // One sticky flop: clear first, then OR in the set strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= INIT;
            else        q[i] <= KEEP & ((q[i] & ~clr) | set_vec[i]);
        end
    end

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((q & $past(q)) == $past(q)));                     // R9
    AST_CLEAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == ($past(set_vec) & IMPL)));                    // R10
    AST_UNUSED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~IMPL) == '0);                                         // R8
endmodule

// File: rtl/esr_summary.sv
// Enable mask register and masked summary.  The mask loads on a
// write strobe; the summary is the OR of register AND mask, and is
// also placed at one position of a status-byte fragment.
// Assumes the summary is consumed combinationally downstream.
module esr_summary #(
    parameter int W       = 8,
    parameter int SUM_POS = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    input  logic [W-1:0] status,
    output logic [W-1:0] mask_q,
    output logic         esb,
    output logic [W-1:0] stb_frag
);
    // Mask storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // Masked OR reduction.
    assign esb = |(status & mask_q);

    for (genvar i = 0; i < W; i++) begin : g_frag
        if (i == SUM_POS) begin : g_sum
            assign stb_frag[i] = esb;
        end else begin : g_zero
            assign stb_frag[i] = 1'b0;
        end
    end

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata)));                 // R11
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));                              // R11
    AST_ESB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !esb);                                   // R12
endmodule

// File: rtl/event_status_reg.sv
// Top of the sticky event status register.  Wires the event map,
// the sticky bit array and the mask/summary stage together and
// merges the two clear strobes.
// Assumes all inputs are synchronous to clk.
module event_status_reg
    import esr_pkg::*;
#(
    parameter int PAR_N = 4,
    parameter int EXE_N = 3,
    parameter int QRY_N = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_resume,
    input  logic [PAR_N-1:0] parse_err,
    input  logic [EXE_N-1:0] exec_err,
    input  logic             dev_fault,
    input  logic [QRY_N-1:0] qry_err,
    input  logic             opc_done,
    input  logic             user_req,
    input  logic             ctl_req,
    input  logic             clr_status,
    input  logic             err_query,
    input  logic             mask_we,
    input  logic [ESR_W-1:0] mask_wdata,
    output logic [ESR_W-1:0] status_q,
    output logic [ESR_W-1:0] mask_q,
    output logic             esb,
    output logic [ESR_W-1:0] stb_frag,
    output logic             oq_flush
);
    logic [ESR_W-1:0] set_vec;
    logic             clr_any;

    // Either command clears the register.
    assign clr_any = clr_status | err_query;

    esr_event_map #(.PAR_N(PAR_N), .EXE_N(EXE_N), .QRY_N(QRY_N)) u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_resume (pwr_resume),
        .parse_err  (parse_err),
        .exec_err   (exec_err),
        .dev_fault  (dev_fault),
        .qry_err    (qry_err),
        .opc_done   (opc_done),
        .user_req   (user_req),
        .ctl_req    (ctl_req),
        .set_vec    (set_vec),
        .oq_flush   (oq_flush)
    );

    esr_sticky_bits #(.W(ESR_W), .IMPL(ESR_IMPL), .RST_VAL(ESR_RST)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr_any),
        .set_vec (set_vec),
        .q       (status_q)
    );

    esr_summary #(.W(ESR_W), .SUM_POS(SB_SUM_POS)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .status     (status_q),
        .mask_q     (mask_q),
        .esb        (esb),
        .stb_frag   (stb_frag)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (status_q == ESR_RST) && (mask_q == '0) && !oq_flush); // R1
    AST_OPC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        opc_done |=> status_q[POS_OPC]);                            // R6
    AST_PON_SET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_resume |=> status_q[POS_PON]);                          // R7
    AST_DEV_SET: assert property (@(posedge clk) disable iff (!rst_n)
        dev_fault |=> status_q[POS_DEV]);                           // R4
    AST_EXE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|exec_err) |=> status_q[POS_EXE]);                         // R3
    AST_FRAG_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_frag[SB_SUM_POS] == esb) && ($countones(stb_frag) <= 1)); // R12
endmodule

// File: tb/event_status_reg_test.sv
// Bench: behavioural reference model updated once per cycle and
// compared against every output at the falling edge.
module event_status_reg_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_resume = 1'b0;
    logic [3:0] parse_err = '0;
    logic [2:0] exec_err = '0;
    logic       dev_fault = 1'b0;
    logic [2:0] qry_err = '0;
    logic       opc_done = 1'b0;
    logic       user_req = 1'b0;
    logic       ctl_req = 1'b0;
    logic       clr_status = 1'b0;
    logic       err_query = 1'b0;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic [7:0] status_q, mask_q, stb_frag;
    logic       esb, oq_flush;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;
    string cur_req = "R1";

    logic [7:0] exp_st = 8'h80;
    logic [7:0] exp_mk = 8'h00;
    logic       exp_fl = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    event_status_reg uut (
        .clk(clk), .rst_n(rst_n), .pwr_resume(pwr_resume),
        .parse_err(parse_err), .exec_err(exec_err), .dev_fault(dev_fault),
        .qry_err(qry_err), .opc_done(opc_done), .user_req(user_req),
        .ctl_req(ctl_req), .clr_status(clr_status), .err_query(err_query),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .status_q(status_q),
        .mask_q(mask_q), .esb(esb), .stb_frag(stb_frag), .oq_flush(oq_flush)
    );

    task automatic chk(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    // Advance the model with the inputs now applied, then compare after the edge.
    task automatic step();
        logic [7:0] nxt;
        logic       e;
        if (!rst_n) begin
            nxt = 8'h80;
            exp_mk = 8'h00;
            exp_fl = 1'b0;
        end else begin
            nxt = (clr_status || err_query) ? 8'h00 : exp_st;
            if (pwr_resume)      nxt[7] = 1'b1;
            if (parse_err != 0)  nxt[5] = 1'b1;
            if (exec_err != 0)   nxt[4] = 1'b1;
            if (dev_fault)       nxt[3] = 1'b1;
            if (qry_err != 0)    nxt[2] = 1'b1;
            if (opc_done)        nxt[0] = 1'b1;
            if (mask_we)         exp_mk = mask_wdata;
            exp_fl = (qry_err != 0);
        end
        exp_st = nxt;
        @(negedge clk);
        e = 1'b0;
        for (int i = 0; i < 8; i++) if (exp_st[i] && exp_mk[i]) e = 1'b1;
        chk(cur_req, "status", status_q, exp_st);
        chk(cur_req, "mask", mask_q, exp_mk);
        chk(cur_req, "esb", {7'd0, esb}, {7'd0, e});
        chk(cur_req, "frag", stb_frag, e ? 8'h20 : 8'h00);
        chk(cur_req, "flush", {7'd0, oq_flush}, {7'd0, exp_fl});
    endtask

    task automatic idle();
        pwr_resume = 0; parse_err = 0; exec_err = 0; dev_fault = 0;
        qry_err = 0; opc_done = 0; user_req = 0; ctl_req = 0;
        clr_status = 0; err_query = 0; mask_we = 0; mask_wdata = 0;
    endtask

    task automatic clear_reg();
        idle(); clr_status = 1; step(); idle();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        idle();
        rst_n = 0; step(); step(); step();
        rst_n = 1; step();

        // R2: each parser error kind sets the command-error bit
        for (int k = 0; k < 4; k++) begin
            clear_reg();
            cur_req = "R2";
            parse_err = 4'b1 << k; step(); idle(); step();
        end

        // R3: each execution error kind
        for (int k = 0; k < 3; k++) begin
            clear_reg();
            cur_req = "R3";
            exec_err = 3'b1 << k; step(); idle(); step();
        end

        // R4: internal fault
        clear_reg(); cur_req = "R4";
        dev_fault = 1; step(); idle(); step();

        // R5: query errors and flush pulse, including back-to-back strobes
        for (int k = 0; k < 3; k++) begin
            clear_reg(); cur_req = "R5";
            qry_err = 3'b1 << k; step(); idle(); step(); step();
        end
        clear_reg(); cur_req = "R5";
        qry_err = 3'b011; step(); qry_err = 3'b100; step(); idle(); step();

        // R6: operation complete
        clear_reg(); cur_req = "R6";
        opc_done = 1; step(); idle(); step();

        // R7: power recovery after a clear
        clear_reg(); cur_req = "R7";
        pwr_resume = 1; step(); idle(); step();

        // R8: unused strobes ignored, mask fully open
        clear_reg(); cur_req = "R8";
        mask_we = 1; mask_wdata = 8'hFF; step(); idle();
        user_req = 1; ctl_req = 1; step(); step(); idle(); step();

        // R9: bits hold across idle cycles
        cur_req = "R9";
        dev_fault = 1; opc_done = 1; step(); idle();
        for (int k = 0; k < 6; k++) step();

        // R10: clear together with set keeps the new event; error query clears too
        cur_req = "R10";
        exec_err = 3'b010; step(); idle();
        clr_status = 1; parse_err = 4'b0100; step(); idle(); step();
        err_query = 1; step(); idle(); step();
        err_query = 1; qry_err = 3'b001; step(); idle(); step();

        // R11: mask writes and holds
        cur_req = "R11";
        mask_we = 1; mask_wdata = 8'h5A; step(); idle(); step(); step();
        mask_we = 1; mask_wdata = 8'h00; step(); idle(); step();

        // R12: summary follows register and mask
        clear_reg(); cur_req = "R12";
        mask_we = 1; mask_wdata = 8'h20; step(); idle(); step();
        parse_err = 4'b0001; step(); idle(); step();
        mask_we = 1; mask_wdata = 8'hDF; step(); idle(); step();
        mask_we = 1; mask_wdata = 8'h30; step(); idle(); step();
        clr_status = 1; step(); idle(); step();

        // R9: random traffic with rare clears
        cur_req = "R9";
        for (int k = 0; k < 300; k++) begin
            int unsigned r;
            r = $urandom;
            idle();
            pwr_resume = (r[3:0] == 0);
            parse_err  = (r[6:4] == 0) ? r[10:7] : 4'd0;
            exec_err   = (r[13:11] == 0) ? r[16:14] : 3'd0;
            dev_fault  = (r[20:17] == 0);
            qry_err    = (r[23:21] == 0) ? r[26:24] : 3'd0;
            opc_done   = (r[29:27] == 0);
            user_req   = r[30];
            ctl_req    = r[31];
            r = $urandom;
            clr_status = (r[4:0] == 0);
            err_query  = (r[9:5] == 0);
            mask_we    = (r[12:10] == 0);
            mask_wdata = r[20:13];
            step();
        end
        idle(); step();

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule